// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port controlled through a small memory-mapped register bank. Software writes an output value and an output-enable mask that drive the pads directly, and reads back the pin levels after a two-flop synchroniser. Each pin can also be routed to interrupt detection. Per pin, it can be set up to trigger on a rising edge, a falling edge, a high level or a low level.

Detected events land in a sticky status register. The status bits are ANDed with an enable mask and ORed into one port-level interrupt request. Every register has three write views at neighbouring word addresses: a plain write, a write-one-to-set view and a write-one-to-clear view. Status can be cleared only through its clear view. The bus uses one strobe with a write flag, a word address and 32-bit data. Read data is registered and appears on the cycle after the read strobe.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `pin_out`, `pin_oe` and `irq` are 0, and `bus_rdata` is 0.
- R2: The access view is `bus_addr[1:0]`: 0 replaces the register, 1 ORs in the 1 bits of the write data, 2 clears the 1 bits, and 3 writes nothing. Bits that are 0 in the data are left unchanged at views 1 and 2. Reads return the register at any view.
- R3: The register is chosen by `bus_addr[8:6]`: 0 output data, 1 input levels, 2 output enable, 3 interrupt select, 4 interrupt enable, 5 trigger level bit, 6 trigger polarity bit, 7 status. `bus_addr[5:2]` must be zero: otherwise a write is ignored and a read returns 0. Read data appears the cycle after the read strobe.
- R4: `pin_out` equals the output data register and `pin_oe` equals the output enable register.
- R5: Register 1 returns `pin_in` delayed by two clock edges, and writes to it are ignored.
- R6: The trigger of pin i is {polarity[i], level[i]}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. An edge on `pin_in` sets the status bit on the third rising clock edge after the change.
- R7: A pin whose select bit is 0 never sets its status bit.
- R8: Status bits stay set until a 1 is written to them at view 2. Writes at views 0 and 1 leave status unchanged.
- R9: In a level mode the status bit is set again on every cycle the level is active, so clearing it has no lasting effect.
- R10: When a detected event and a clear hit the same status bit on the same edge, the bit ends up set.
- R11: Status bits are set whatever the enable mask holds. `irq` is 1 exactly when status AND enable is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Word address: register index, zero field, access view |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables, 1 = drive |
| irq | output | 1 | Port interrupt request |

## Verification
The register views are exercised with overlapping patterns. This shows that set, clear, replace and the dead view each touch only the bits they should.

The trigger logic is driven with pin sequences that cover each of the four codes in turn. These include a rise on a falling-edge pin, which must stay silent, and a level pin that stays active while software clears it, which separates level behaviour from edge behaviour. A rise on an unselected pin checks the select gate. A clear timed onto the exact edge where an event lands checks set-over-clear priority.

Enable is toggled while status is non-zero, which separates status capture from interrupt gating.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the GPIO port.
// Assumes eight register slots and a two-bit access view field.
package gpio_port_pkg;

    localparam int REG_SLOTS = 8;

    typedef enum logic [2:0] {
        SEL_DOUT  = 3'd0,
        SEL_DIN   = 3'd1,
        SEL_OE    = 3'd2,
        SEL_ISEL  = 3'd3,
        SEL_IEN   = 3'd4,
        SEL_ILVL  = 3'd5,
        SEL_IPOL  = 3'd6,
        SEL_ISTAT = 3'd7
    } reg_slot_e;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLEAR = 2'd2,
        ACC_NONE  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        TRIG_FALL = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_code_e;

    // Result of one register write through a given view
    function automatic logic [31:0] apply_access(input logic [31:0] old_v,
                                                 input logic [31:0] data,
                                                 input access_e     acc);
        case (acc)
            ACC_WRITE: apply_access = data;
            ACC_SET:   apply_access = old_v | data;
            ACC_CLEAR: apply_access = old_v & ~data;
            default:   apply_access = old_v;
        endcase
    endfunction

    // Single-pin trigger match from the code, current and previous level
    function automatic logic trig_hit(input trig_code_e code,
                                      input logic now_v,
                                      input logic before_v);
        case (code)
            TRIG_FALL: trig_hit = before_v & ~now_v;
            TRIG_LOW:  trig_hit = ~now_v;
            TRIG_RISE: trig_hit = now_v & ~before_v;
            default:   trig_hit = now_v;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for asynchronous pad inputs.
// Assumes STAGES >= 2. Output lags the input by STAGES clock edges.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the pad levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_trigger.sv
`timescale 1ns/1ps
// Per-pin trigger detection on synchronised pin levels.
// Keeps one previous sample per pin; events are gated by the select mask.
module gpio_pin_trigger
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] isel,
    input  logic [WIDTH-1:0] ilvl,
    input  logic [WIDTH-1:0] ipol,
    output logic [WIDTH-1:0] evt
);
    logic [WIDTH-1:0] prev;

    // Hold the previous synchronised sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= pin_s;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Match the pin against its own trigger code
        assign evt[i] = isel[i] &
                        trig_hit(trig_code_e'({ipol[i], ilvl[i]}), pin_s[i], prev[i]);
    end

    // R6
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & ~ilvl & ~(pin_s ^ prev)) == '0));

endmodule

// File: rtl/gpio_cfg_regs.sv
`timescale 1ns/1ps
// Writable register bank with replace, set and clear views.
// Slots for input levels and status are not stored here and read as zero.
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  reg_slot_e                        slot,
    input  access_e                          acc,
    input  logic [WIDTH-1:0]                 wdata,
    output logic [REG_SLOTS-1:0][WIDTH-1:0]  bank,
    output logic [WIDTH-1:0]                 stat_clr
);
    for (genvar g = 0; g < REG_SLOTS; g++) begin : g_slot
        if (g == int'(SEL_DIN) || g == int'(SEL_ISTAT)) begin : g_ro
            assign bank[g] = '0;
        end else begin : g_rw
            logic [WIDTH-1:0] q;
            // Update this slot through the addressed view
            always_ff @(posedge clk) begin
                if (!rst_n)                                  q <= '0;
                else if (wr_en && slot == reg_slot_e'(g))    q <= apply_access(q, wdata, acc);
            end
            assign bank[g] = q;
        end
    end

    // Status is cleared only through its clear view
    assign stat_clr = (wr_en && slot == SEL_ISTAT && acc == ACC_CLEAR) ? wdata : '0;

    // R2
    set_view_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc == ACC_SET && slot == SEL_OE) |=>
        ((bank[SEL_OE] & $past(bank[SEL_OE])) == $past(bank[SEL_OE])));

    // R2
    dead_view_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || acc == ACC_NONE) |=> $stable(bank));

endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
// Sticky interrupt status with set-over-clear priority and the port request.
// Assumes evt and clr arrive in the same cycle they take effect.
module gpio_irq_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic [WIDTH-1:0] clr,
    input  logic [WIDTH-1:0] ien,
    output logic [WIDTH-1:0] stat,
    output logic             irq
);
    // Capture events; a clear loses to an event on the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr) | evt;
    end

    // Combine enabled status into the single request
    assign irq = |(stat & ien);

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & $past(evt)) == $past(evt)));

    // R8
    clear_only_by_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat) & ~stat & ~$past(clr)) == '0));

    // R11
    masked_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
// GPIO port top: bus decode, registered read mux, pad drive,
// input synchronisation, trigger detection and interrupt status.
// Assumes one access per strobe cycle and ADDR_W == SLOT_LSB + 3.
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int N_PINS      = 32,
    parameter int SLOT_STRIDE = 256,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);
    localparam int SLOT_LSB = $clog2(SLOT_STRIDE / 4);

    reg_slot_e                         slot;
    access_e                           acc;
    logic                              addr_ok;
    logic                              wr_en;
    logic                              rd_fire;
    logic [REG_SLOTS-1:0][N_PINS-1:0]  bank;
    logic [N_PINS-1:0]                 stat_clr;
    logic [N_PINS-1:0]                 pin_sync;
    logic [N_PINS-1:0]                 evt;
    logic [N_PINS-1:0]                 stat;
    logic [N_PINS-1:0]                 rd_word;

    // Decode slot, view and the must-be-zero field
    assign slot    = reg_slot_e'(bus_addr[SLOT_LSB +: 3]);
    assign acc     = access_e'(bus_addr[1:0]);
    assign addr_ok = (bus_addr[SLOT_LSB-1:2] == '0);
    assign wr_en   = bus_sel & bus_we & addr_ok;
    assign rd_fire = bus_sel & ~bus_we;

    gpio_cfg_regs #(.WIDTH(N_PINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .slot     (slot),
        .acc      (acc),
        .wdata    (bus_wdata),
        .bank     (bank),
        .stat_clr (stat_clr)
    );

    gpio_in_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_pin_trigger #(.WIDTH(N_PINS)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_s (pin_sync),
        .isel  (bank[SEL_ISEL]),
        .ilvl  (bank[SEL_ILVL]),
        .ipol  (bank[SEL_IPOL]),
        .evt   (evt)
    );

    gpio_irq_status #(.WIDTH(N_PINS)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (stat_clr),
        .ien   (bank[SEL_IEN]),
        .stat  (stat),
        .irq   (irq)
    );

    // Pick the word a read returns
    always_comb begin
        case (slot)
            SEL_DIN:   rd_word = pin_sync;
            SEL_ISTAT: rd_word = stat;
            default:   rd_word = bank[slot];
        endcase
    end

    // Register read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       bus_rdata <= '0;
        else if (rd_fire) bus_rdata <= addr_ok ? rd_word : '0;
    end

    assign pin_out = bank[SEL_DOUT];
    assign pin_oe  = bank[SEL_OE];

    // R5
    din_read_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && addr_ok && slot == SEL_DIN) |=> (bus_rdata == $past(pin_sync)));

    // R3
    bad_addr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !addr_ok) |=> (bus_rdata == '0));

    // R7
    unselected_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(bank[SEL_ISEL])) == '0));

endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bsel = 1'b0;
    logic        bwe = 1'b0;
    logic [8:0]  baddr = '0;
    logic [31:0] bwdata = '0;
    logic [31:0] rdata;
    logic [31:0] pins = '0;
    logic [31:0] pout;
    logic [31:0] poe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit run = 0;

    always #2 clk = ~clk;

    gpio_irq_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_we(bwe),
        .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(rdata),
        .pin_in(pins), .pin_out(pout), .pin_oe(poe), .irq(irq)
    );

    // Behavioural reference: registers indexed 0..7, pin history queue
    logic [31:0] mr [8];
    logic [31:0] hist [$];
    logic [31:0] m_prev;
    logic [31:0] m_rd;
    logic [31:0] m_evt;

    function automatic logic [31:0] m_sync();
        return (hist.size() >= 2) ? hist[1] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) mr[k] = '0;
            hist.delete(); hist.push_front(32'h0); hist.push_front(32'h0);
            m_prev = '0; m_rd = '0;
        end else begin
            logic [31:0] now_s;
            int idx, av;
            bit valid;
            now_s = m_sync();
            for (int i = 0; i < 32; i++) begin
                logic h;
                case ({mr[6][i], mr[5][i]})
                    2'b00: h = m_prev[i] & ~now_s[i];
                    2'b01: h = ~now_s[i];
                    2'b10: h = now_s[i] & ~m_prev[i];
                    default: h = now_s[i];
                endcase
                m_evt[i] = h & mr[3][i];
            end
            idx = int'(baddr[8:6]);
            av = int'(baddr[1:0]);
            valid = (baddr[5:2] == 4'd0);
            if (bsel && !bwe)
                m_rd = !valid ? 32'h0 : (idx == 1 ? now_s : mr[idx]);
            if (bsel && bwe && valid && idx != 1) begin
                if (idx == 7) begin
                    if (av == 2) mr[7] = mr[7] & ~bwdata;
                end else begin
                    case (av)
                        0: mr[idx] = bwdata;
                        1: mr[idx] = mr[idx] | bwdata;
                        2: mr[idx] = mr[idx] & ~bwdata;
                        default: ;
                    endcase
                end
            end
            mr[7] = mr[7] | m_evt;
            m_prev = now_s;
            hist.push_front(pins);
            while (hist.size() > 2) void'(hist.pop_back());
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference (R3 read data, R4 pads, R11 irq)
    always @(negedge clk) begin
        if (run && rst_n) begin
            chk(rdata == m_rd, "R3 read data vs model", rdata, m_rd);
            chk(pout == mr[0], "R4 pin_out vs model", pout, mr[0]);
            chk(poe == mr[2], "R4 pin_oe vs model", poe, mr[2]);
            chk(irq == |(mr[7] & mr[4]), "R11 irq vs model", {31'd0, irq}, {31'd0, |(mr[7] & mr[4])});
        end
    end

    task automatic access(bit we, logic [8:0] a, logic [31:0] d);
        bsel = 1'b1; bwe = we; baddr = a; bwdata = d;
        @(posedge clk); @(negedge clk);
        bsel = 1'b0; bwe = 1'b0;
    endtask

    task automatic wr(int idx, int av, logic [31:0] d);
        access(1'b1, {idx[2:0], 4'd0, av[1:0]}, d);
    endtask

    task automatic rd(int idx, int av, logic [31:0] exp, string tag);
        access(1'b0, {idx[2:0], 4'd0, av[1:0]}, 32'h0);
        chk(rdata == exp, tag, rdata, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        // R1 reset state
        chk(pout == 0 && poe == 0, "R1 pads after reset", pout | poe, 32'h0);
        chk(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 32'h0);
        chk(rdata == 0, "R1 rdata after reset", rdata, 32'h0);
        for (int k = 0; k < 8; k++) rd(k, 0, 32'h0, "R1 register zero");

        // R2 views on output data
        wr(0, 0, 32'hA5A5_0F0F);
        rd(0, 0, 32'hA5A5_0F0F, "R2 replace view");
        wr(0, 1, 32'h0000_F0F0);
        rd(0, 1, 32'hA5A5_FFFF, "R2 set view");
        wr(0, 2, 32'hA500_000F);
        rd(0, 2, 32'h00A5_FFF0, "R2 clear view");
        wr(0, 3, 32'hFFFF_FFFF);
        rd(0, 0, 32'h00A5_FFF0, "R2 dead view ignored");
        chk(pout == 32'h00A5_FFF0, "R4 pin_out follows data", pout, 32'h00A5_FFF0);
        wr(2, 1, 32'h0000_FF00);
        chk(poe == 32'h0000_FF00, "R4 pin_oe follows enable", poe, 32'h0000_FF00);

        // R3 bad middle field
        access(1'b1, 9'b000_0100_00, 32'h1234_0000);
        rd(0, 0, 32'h00A5_FFF0, "R3 write to bad address ignored");
        access(1'b0, 9'b010_0010_00, 32'h0);
        chk(rdata == 0, "R3 bad address reads zero", rdata, 32'h0);

        // R5 synchronised input levels
        pins = 32'h1234_5678;
        settle();
        rd(1, 0, 32'h1234_5678, "R5 input levels");
        wr(1, 0, 32'hFFFF_FFFF);
        rd(1, 0, 32'h1234_5678, "R5 write to input ignored");
        pins = 32'h0;
        settle();

        // Trigger setup: pin0 rise, pin1 fall, pin2 low, pin3 high, pin4 rise unselected, pin5 rise
        wr(6, 0, 32'h39);
        wr(5, 0, 32'h0C);
        wr(3, 0, 32'h2F);
        wr(7, 2, 32'hFFFF_FFFF);
        rd(7, 0, 32'h4, "R9 low level re-sets after clear");

        pins = 32'h1; settle();
        rd(7, 0, 32'h5, "R6 rising edge code 10");
        pins = 32'h3; settle();
        rd(7, 0, 32'h5, "R6 rise ignored on falling pin");
        pins = 32'h1; settle();
        rd(7, 0, 32'h7, "R6 falling edge code 00");
        pins = 32'h9; settle();
        rd(7, 0, 32'hF, "R6 high level code 11");

        chk(irq == 1'b0, "R11 status set with enable zero", {31'd0, irq}, 32'h0);
        wr(4, 1, 32'h1);
        chk(irq == 1'b1, "R11 irq with enabled status", {31'd0, irq}, 32'h1);

        wr(7, 0, 32'h0);
        wr(7, 1, 32'hFFFF_FFFF);
        rd(7, 0, 32'hF, "R8 replace and set views leave status");
        wr(7, 2, 32'h3);
        rd(7, 0, 32'hC, "R8 clear view clears edge bits");
        chk(irq == 1'b0, "R11 irq drops after clear", {31'd0, irq}, 32'h0);

        pins = 32'h19; settle();
        rd(7, 0, 32'hC, "R7 unselected pin sets nothing");

        pins = 32'h39;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr(7, 2, 32'h20);
        rd(7, 0, 32'h2C, "R10 event beats same-cycle clear");
        wr(7, 2, 32'h20);
        rd(7, 0, 32'hC, "R8 later clear takes effect");
        wr(7, 2, 32'h8);
        rd(7, 0, 32'hC, "R9 high level holds after clear");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule